// File: doc/BRIEF.md
# Weighted Random Stall Injector

This block produces stall requests for three ready/valid handshake points in a random-number storage path, for use in test mode. The points are writes into the normal store, writes into the no-zeros store and reads out of the no-zeros store. Each point has its own enable and its own 2-bit duty weight. The stall outputs are meant to be ANDed into the handshakes by the surrounding logic.

A free-running 16-bit linear feedback shift register supplies the random bits. It moves one step only when a programmable interval counter expires, so stalls can be slowed relative to the clock. At every step each enabled point registers a new stall decision and holds it until the next step. The decision comes from two LFSR bits reserved for that point, read through the point's weight. The configuration arrives on plain input ports.

Top module: `stall_injector`

## Requirements
- R1: While `rst_n` is low and after its release up to the first LFSR step, all three bits of `pt_stall` are 0.
- R2: A point whose `pt_enable` bit is 0 shows 0 on its `pt_stall` bit in every cycle, including the cycle in which the enable is cleared, whatever its weight.
- R3: Weight code 0 makes an enabled point's stall 1 after every LFSR step.
- R4: Weight code 1 makes an enabled point stall after 75% of steps, within ±5% over 4096 steps.
- R5: Weight code 2 makes an enabled point stall after 50% of steps, within ±5% over 4096 steps.
- R6: Weight code 3 makes an enabled point stall after 25% of steps, within ±5% over 4096 steps.
- R7: Bit 2 of `pt_enable`/`pt_stall` and bits [5:4] of `pt_weight` belong to normal-store writes. Bit 1 and bits [3:2] belong to no-zeros-store writes. Bit 0 and bits [1:0] belong to no-zeros-store reads.
- R8: With `step_gap` = N, the LFSR steps once every N+1 clock cycles. The first step falls on the (N+1)-th rising edge after reset is released. `pt_stall` of an enabled point changes only on step edges.
- R9: The LFSR never holds the all-zero state, so the stall pattern keeps changing at weight 2.
- R10: The full 12-bit interval works: with `step_gap` = 4095 the first step falls on edge 4096 after reset release, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_enable | input | 3 | Per-point injection enable (bit 2 normal write, bit 1 no-zeros write, bit 0 no-zeros read) |
| pt_weight | input | 6 | Two-bit duty code per point: 0 always, 1 three quarters, 2 half, 3 one quarter |
| step_gap | input | 12 | LFSR step interval in clock cycles minus one |
| pt_stall | output | 3 | Stall request per point, same bit order as the enable |

## Verification
The duty ratios can only be reached through long runs. Each ratio emerges only over thousands of LFSR steps, so the bench fixes the step interval at zero and rotates the three weights across the points over four runs of 4096 steps each. That way every point meets every weight, and the packing order is checked in the same runs. The largest interval is the other hard case, because it takes 4096 cycles to reach one step. The bench waits out that interval with weight 0 and checks the exact edge on which the first stall appears.

// File: rtl/stall_inj_pkg.sv
package stall_inj_pkg;

   localparam int NUM_POINTS = 3;
   localparam int PT_NZ_RD   = 0;
   localparam int PT_NZ_WR   = 1;
   localparam int PT_NML_WR  = 2;

   typedef enum logic [1:0] {
      DUTY_ALL     = 2'd0,
      DUTY_3Q      = 2'd1,
      DUTY_HALF    = 2'd2,
      DUTY_1Q      = 2'd3
   } duty_t;

   // first LFSR bit sampled by point idx
   function automatic int pick_a(input int idx, input int width);
      return (3 * idx + 1) % width;
   endfunction

   // second LFSR bit, half a register away from the first
   function automatic int pick_b(input int idx, input int width);
      return (3 * idx + 1 + width / 2) % width;
   endfunction

   // Fibonacci feedback masks for supported widths (bit k = tap k+1)
   function automatic logic [31:0] tap_mask(input int width);
      logic [31:0] m;
      m = '0;
      case (width)
         8:  m = 32'h0000_00B8;  // taps 8,6,5,4
         16: m = 32'h0000_B400;  // taps 16,14,13,11
         24: m = 32'h00E1_0000;  // taps 24,23,22,17
         32: m = 32'h8020_0003;  // taps 32,22,2,1
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/stall_inj_timer.sv
module stall_inj_timer #(
   parameter int GAP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GAP_W-1:0] gap,
   output logic             tick
);

   generate
      if (GAP_W < 1 || GAP_W > 31) begin : g_bad_width
         $error("stall_inj_timer: GAP_W out of range");
      end
   endgenerate

   logic [GAP_W-1:0] cnt_q;

   // ">=" lets a shrunk interval take effect at once instead of wrapping
   assign tick = (cnt_q >= gap);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/stall_inj_lfsr.sv
module stall_inj_lfsr
   import stall_inj_pkg::*;
#(
   parameter int          WIDTH = 16,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WIDTH-1:0] state
);

   localparam logic [31:0]      MASK32   = tap_mask(WIDTH);
   localparam logic [WIDTH-1:0] MASK     = MASK32[WIDTH-1:0];
   localparam logic [WIDTH-1:0] SEED_W   = SEED[WIDTH-1:0];

   generate
      if (MASK32 == 32'd0) begin : g_bad_width
         $error("stall_inj_lfsr: unsupported WIDTH");
      end
      if (SEED_W == '0) begin : g_bad_seed
         $error("stall_inj_lfsr: SEED must be nonzero");
      end
   endgenerate

   logic             fb;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] state_q;

   assign fb  = ^(state_q & MASK);
   assign nxt = {state_q[WIDTH-2:0], fb};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED_W;
      end else if (step) begin
         // lock-up guard: reload the seed rather than stick at zero
         state_q <= (nxt == '0) ? SEED_W : nxt;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/stall_inj_point.sv
module stall_inj_point
   import stall_inj_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int BIT_A = 1,
   parameter int BIT_B = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [1:0]       weight,
   input  logic [WIDTH-1:0] rnd,
   output logic             stall_q
);

   generate
      if (BIT_A == BIT_B) begin : g_same_bits
         $error("stall_inj_point: the two sampled bits must differ");
      end
      if (BIT_A < 0 || BIT_A >= WIDTH || BIT_B < 0 || BIT_B >= WIDTH) begin : g_bad_bits
         $error("stall_inj_point: sampled bit out of range");
      end
   endgenerate

   logic  bit_a;
   logic  bit_b;
   logic  decide;
   duty_t duty;

   assign bit_a = rnd[BIT_A];
   assign bit_b = rnd[BIT_B];
   assign duty  = duty_t'(weight);

   always_comb begin
      unique case (duty)
         DUTY_ALL:  decide = 1'b1;
         DUTY_3Q:   decide = bit_a | bit_b;
         DUTY_HALF: decide = bit_a;
         DUTY_1Q:   decide = bit_a & bit_b;
         default:   decide = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
      end else if (step) begin
         stall_q <= decide;
      end
   end

endmodule

// File: rtl/stall_injector.sv
module stall_injector
   import stall_inj_pkg::*;
#(
   parameter int          LFSR_W = 16,
   parameter logic [31:0] SEED   = 32'h0000_ACE1,
   parameter int          GAP_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_POINTS-1:0]   pt_enable,
   input  logic [2*NUM_POINTS-1:0] pt_weight,
   input  logic [GAP_W-1:0]        step_gap,
   output logic [NUM_POINTS-1:0]   pt_stall
);

   logic                  step_tick;
   logic [LFSR_W-1:0]     lfsr_q;
   logic [NUM_POINTS-1:0] point_q;

   stall_inj_timer #(
      .GAP_W (GAP_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .gap   (step_gap),
      .tick  (step_tick)
   );

   stall_inj_lfsr #(
      .WIDTH (LFSR_W),
      .SEED  (SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step_tick),
      .state (lfsr_q)
   );

   generate
      for (genvar p = 0; p < NUM_POINTS; p++) begin : g_point
         stall_inj_point #(
            .WIDTH (LFSR_W),
            .BIT_A (pick_a(p, LFSR_W)),
            .BIT_B (pick_b(p, LFSR_W))
         ) u_point (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step_tick),
            .weight  (pt_weight[2*p +: 2]),
            .rnd     (lfsr_q),
            .stall_q (point_q[p])
         );
      end
   endgenerate

   // enable gates the registered decision so a disable acts in the same cycle
   assign pt_stall = point_q & pt_enable;

endmodule

// File: rtl/stall_injector_chk.sv
module stall_injector_chk #(
   parameter int NP     = 3,
   parameter int LFSR_W = 16,
   parameter int GAP_W  = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_tick,
   input  logic [LFSR_W-1:0] lfsr_q,
   input  logic [NP-1:0]   point_q,
   input  logic [NP-1:0]   pt_enable,
   input  logic [2*NP-1:0] pt_weight,
   input  logic [GAP_W-1:0] step_gap,
   input  logic [NP-1:0]   pt_stall
);

   logic [GAP_W:0]   since_q;
   logic [GAP_W-1:0] gap_q;
   logic             dirty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
         gap_q   <= step_gap;
         dirty_q <= 1'b0;
      end else begin
         gap_q   <= step_gap;
         since_q <= step_tick ? '0 : since_q + 1'b1;
         dirty_q <= step_tick ? 1'b0 : (dirty_q | (step_gap != gap_q));
      end
   end

   assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   assert_step_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_tick && !dirty_q && step_gap == gap_q) |-> (since_q == {1'b0, step_gap}));

   assert_no_early_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dirty_q && step_gap == gap_q && since_q < {1'b0, step_gap}) |-> !step_tick);

   assert_hold_between_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_tick |=> $stable(point_q));

   generate
      for (genvar p = 0; p < NP; p++) begin : g_pt
         assert_full_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (step_tick && pt_enable[p] && pt_weight[2*p +: 2] == 2'd0) |=>
               (pt_enable[p] -> pt_stall[p]));
      end
   endgenerate

endmodule

bind stall_injector stall_injector_chk #(
   .NP     (stall_inj_pkg::NUM_POINTS),
   .LFSR_W (LFSR_W),
   .GAP_W  (GAP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_tick (step_tick),
   .lfsr_q    (lfsr_q),
   .point_q   (point_q),
   .pt_enable (pt_enable),
   .pt_weight (pt_weight),
   .step_gap  (step_gap),
   .pt_stall  (pt_stall)
);

// File: tb/stall_injector_test.sv
module stall_injector_test;

   localparam int CLK_PERIOD = 10;
   localparam int RUN_STEPS  = 4096;
   localparam int TOL        = RUN_STEPS * 5 / 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  pt_enable = '0;
   logic [5:0]  pt_weight = '0;
   logic [11:0] step_gap = '0;
   logic [2:0]  pt_stall;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stall_injector uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pt_enable (pt_enable),
      .pt_weight (pt_weight),
      .step_gap  (step_gap),
      .pt_stall  (pt_stall)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // holds reset, then releases it at a falling edge; next posedge is edge 1
   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pt_stall == 3'b000, "R1 stall during reset", pt_stall, 0);
      rst_n = 1'b1;
   endtask

   function automatic int nominal(input int w);
      return RUN_STEPS * (4 - w) / 4;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt [3];
      int w   [3];
      int changes;
      logic [2:0] prev;
      bit bad;

      // R4 R5 R6 R3 R7: ratio sweep, weights rotated across points
      for (int r = 0; r < 4; r++) begin
         for (int p = 0; p < 3; p++) begin
            w[p] = (r + p) % 4;
            cnt[p] = 0;
         end
         pt_enable = 3'b111;
         step_gap  = 12'd0;
         pt_weight = {w[2][1:0], w[1][1:0], w[0][1:0]};
         do_reset();
         for (int e = 0; e < RUN_STEPS; e++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) cnt[p] += int'(pt_stall[p]);
         end
         for (int p = 0; p < 3; p++) begin
            if (w[p] == 0)
               check(cnt[p] == RUN_STEPS, "R3 R7 weight 0 always stalls", cnt[p], RUN_STEPS);
            else if (w[p] == 1)
               check(cnt[p] >= nominal(1) - TOL && cnt[p] <= nominal(1) + TOL,
                     "R4 R7 weight 1 ratio", cnt[p], nominal(1));
            else if (w[p] == 2)
               check(cnt[p] >= nominal(2) - TOL && cnt[p] <= nominal(2) + TOL,
                     "R5 R7 weight 2 ratio", cnt[p], nominal(2));
            else
               check(cnt[p] >= nominal(3) - TOL && cnt[p] <= nominal(3) + TOL,
                     "R6 R7 weight 3 ratio", cnt[p], nominal(3));
         end
      end

      // R2: only the no-zeros write point enabled, all weights 0
      pt_enable = 3'b010;
      pt_weight = 6'b00_00_00;
      step_gap  = 12'd0;
      do_reset();
      bad = 1'b0;
      for (int e = 0; e < 500; e++) begin
         @(negedge clk);
         if (pt_stall != 3'b010) bad = 1'b1;
      end
      check(!bad, "R2 disabled points stay quiet", pt_stall, 3'b010);
      // clear the enable mid-stream: same-cycle effect
      pt_enable = 3'b000;
      #1;
      check(pt_stall == 3'b000, "R2 disable acts at once", pt_stall, 0);
      @(negedge clk);
      check(pt_stall == 3'b000, "R2 disabled next cycle", pt_stall, 0);

      // R8 R9: step spacing at weight 2, changes only on step edges
      for (int k = 0; k < 3; k++) begin
         int n;
         n = (k == 0) ? 1 : (k == 1) ? 3 : 6;
         pt_enable = 3'b111;
         pt_weight = 6'b10_10_10;
         step_gap  = 12'(n);
         do_reset();
         prev = 3'b000;
         bad = 1'b0;
         changes = 0;
         for (int e = 1; e <= (n + 1) * 300; e++) begin
            @(negedge clk);
            if (pt_stall != prev) begin
               changes++;
               if (e % (n + 1) != 0) bad = 1'b1;
            end
            prev = pt_stall;
         end
         check(!bad, "R8 change off a step edge", int'(bad), 0);
         check(changes > 60, "R9 pattern keeps moving", changes, 60);
      end

      // R1 R8: first step lands on edge N+1 for N=5
      pt_enable = 3'b111;
      pt_weight = 6'b00_00_00;
      step_gap  = 12'd5;
      do_reset();
      bad = 1'b0;
      for (int e = 1; e <= 5; e++) begin
         @(negedge clk);
         if (pt_stall != 3'b000) bad = 1'b1;
      end
      check(!bad, "R1 quiet before first step", int'(bad), 0);
      @(negedge clk);
      check(pt_stall == 3'b111, "R8 first step on edge N+1", pt_stall, 7);

      // R10: full-width interval 4095
      step_gap = 12'd4095;
      do_reset();
      repeat (4095) @(negedge clk);
      check(pt_stall == 3'b000, "R10 no step before edge 4096", pt_stall, 0);
      @(negedge clk);
      check(pt_stall == 3'b111, "R10 step on edge 4096", pt_stall, 7);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule